// File: doc/BRIEF.md
# Two-gate interrupt concentrator

This block collects a group of level-type interrupt inputs and presents one active-high summary interrupt to a host processor. Each input has three per-source bits. A pending bit latches the input while the source is enabled. An enable bit decides whether the input can be captured. A mask bit decides whether a captured event reaches the summary line. The host reads and writes a small register file over a single-cycle synchronous port. The data path is 16 bits wide and registers sit 4 bytes apart.

The enable and mask vectors are never written directly. Each one has a set register and a clear register. Ones written to the set register turn the matching bits on, and ones written to the clear register turn them off. This lets several drivers change their own bits without a read-modify-write. The host acknowledges a pending event by writing a one to its bit in the status register. Clearing only one gate does not fully quiet a source. Clearing the enable alone leaves a latched event driving the line. Clearing the mask alone still lets new events latch. A source is silent only when both gates are cleared.

Top module: `irq_concentrator`

## Requirements
- R1: Register offsets, with the low two address bits zero: status 0x00, enable-set 0x04, enable-clear 0x08, mask-set 0x0C, mask-clear 0x10. Read data is registered: the register chosen at a clock edge appears on the read port after that edge. Both the enable-set and enable-clear offsets read the enable vector, and both mask offsets read the mask vector. Any other offset reads zero, and writes to it change nothing.
- R2: After reset, all enable, mask and pending bits are zero, and the summary output is low.
- R3: Each 1 written to enable-set sets that enable bit, and each 1 written to enable-clear clears it. Written zeros leave the enable bits unchanged.
- R4: Writes to mask-set and mask-clear act the same way on the mask vector, which is separate from the enable vector.
- R5: Pending bit n is set after any clock edge at which input n is high and enable bit n is set. It stays set after the input falls. An input whose enable bit is clear is not captured.
- R6: Each 1 written to the status register clears that pending bit, and written zeros leave pending bits unchanged.
- R7: If an acknowledge and a capture hit the same bit at the same edge, the bit stays set. A source still active and enabled therefore reasserts at once.
- R8: The summary output is a register holding the OR over all bits of (pending AND mask). It changes one edge after the pending or mask state that drives it.
- R9: Clearing only the enable keeps an already-pending, masked-in source driving the summary output. Clearing only the mask keeps capture working but holds the output low. With both cleared and the bit acknowledged, the source is silent.
- R10: Writing 0xFFFF to enable-clear, then mask-clear, then status leaves every source disabled, masked and not pending, with the summary output low.
- R11: Data bits at or above the source count are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| src_i | input | NSRC | Level interrupt inputs, one per source |
| irq_o | output | 1 | Active-high summary interrupt |

## Verification
The bench builds the block with 12 sources on a 16-bit data path and a 5-bit address. With 12 sources, the four top data bits have no source behind them. That makes it possible to check that those bits are ignored on write and read back as zero. The 5-bit address leaves three unmapped word offsets above the five registers, so both reads and writes to unmapped space are exercised. Directed sequences drive the inputs against each gating combination. They also hit the same-edge acknowledge/capture collision and the full shutdown sequence.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Word index of each register (byte offset / 4); the host decodes these.
  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_ENSET = 3'd1,
    REG_ENCLR = 3'd2,
    REG_MKSET = 3'd3,
    REG_MKCLR = 3'd4
  } irqc_reg_e;

  localparam int NUM_REGS = 5;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ni = sync_q[1];
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int DW   = 16,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] ack_o,
  output logic [DW-1:0]   rdata_q
);
  localparam int IW = AW - 2;

  logic [NUM_REGS-1:0] hit;
  logic [IW-1:0]       idx;
  logic                aligned;
  logic [NSRC-1:0]     wbits;
  logic [NSRC-1:0]     en_d, mask_d;
  logic                en_ce, mask_ce;
  logic [DW-1:0]       rdata_d;

  assign idx     = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wbits   = wdata_i[NSRC-1:0];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
    assign hit[k] = aligned && (idx == IW'(k));
  end

  function automatic logic [DW-1:0] widen(input logic [NSRC-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  // next state
  always_comb begin
    en_d    = en_q;
    mask_d  = mask_q;
    en_ce   = we_i && (hit[int'(REG_ENSET)] || hit[int'(REG_ENCLR)]);
    mask_ce = we_i && (hit[int'(REG_MKSET)] || hit[int'(REG_MKCLR)]);
    if (hit[int'(REG_ENSET)]) en_d   = en_q | wbits;
    if (hit[int'(REG_ENCLR)]) en_d   = en_q & ~wbits;
    if (hit[int'(REG_MKSET)]) mask_d = mask_q | wbits;
    if (hit[int'(REG_MKCLR)]) mask_d = mask_q & ~wbits;
    ack_o = (we_i && hit[int'(REG_STAT)]) ? wbits : '0;

    rdata_d = '0;
    if (hit[int'(REG_STAT)])                              rdata_d = widen(pend_i);
    if (hit[int'(REG_ENSET)] || hit[int'(REG_ENCLR)])     rdata_d = widen(en_q);
    if (hit[int'(REG_MKSET)] || hit[int'(REG_MKCLR)])     rdata_d = widen(mask_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (mask_ce) mask_q <= mask_d;
      rdata_q <= rdata_d;
    end
  end

  // R3
  en_clr_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && hit[int'(REG_ENCLR)] && (&wbits)) |=> (en_q == '0));

  // R4
  mask_clr_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && hit[int'(REG_MKCLR)] && (&wbits)) |=> (mask_q == '0));

  // R3
  zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (we_i && wbits == '0) |=> ($stable(en_q) && $stable(mask_q)));
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] ack_i,
  output logic [NSRC-1:0] pend_q
);
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] capture;

  // next state: capture has priority over acknowledge
  for (genvar n = 0; n < NSRC; n++) begin : g_bit
    assign capture[n] = src_i[n] & en_i[n];
    always_comb begin
      pend_d[n] = pend_q[n];
      if (ack_i[n])   pend_d[n] = 1'b0;
      if (capture[n]) pend_d[n] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  // R5
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(src_i & en_i)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((src_i & en_i) != '0) |=> ((pend_q & $past(src_i & en_i)) == $past(src_i & en_i)));

  // R6
  ack_all_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ((&ack_i) && ((src_i & en_i) == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            irq_q
);
  logic irq_d;

  always_comb irq_d = |(pend_i & mask_i);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mask_i == '0) |=> !irq_q);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_i == '0) |=> !irq_q);
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator #(
  parameter int NSRC = 16,
  parameter int DW   = 16,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o
);
  logic            rst_ni;
  logic [NSRC-1:0] en_q, mask_q, ack, pend_q;

  irqc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  irqc_regfile #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr),
    .we_i    (bus_we),
    .wdata_i (bus_wdata),
    .pend_i  (pend_q),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .ack_o   (ack),
    .rdata_q (bus_rdata)
  );

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk    (clk),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .en_i   (en_q),
    .ack_i  (ack),
    .pend_q (pend_q)
  );

  irqc_summary #(.NSRC(NSRC)) u_sum (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_q  (irq_o)
  );
endmodule

// File: tb/irq_concentrator_tb_top.sv
module irq_concentrator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 12;
  localparam int DW   = 16;
  localparam int AW   = 5;

  localparam logic [AW-1:0] A_STAT = 5'h00, A_ENS = 5'h04, A_ENC = 5'h08,
                            A_MKS = 5'h0C, A_MKC = 5'h10, A_UN1 = 5'h14, A_UN3 = 5'h1C;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NSRC-1:0] src_i = '0;
  logic            irq_o;

  int total = 0;
  int fails = 0;
  logic [15:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_concentrator #(.NSRC(NSRC), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [AW-1:0] wa;
    logic [15:0]   wd;
    logic [AW-1:0] ra;
    logic [15:0]   ex;
    logic [3:0]    rq;
  } vec_t;

  // write, then read back; rq is the requirement number (R1, R3, R4, R11)
  localparam vec_t TBL [13] = '{
    '{5'h04, 16'h00A5, 5'h04, 16'h00A5, 4'd3},
    '{5'h04, 16'h0000, 5'h08, 16'h00A5, 4'd3},
    '{5'h08, 16'h0005, 5'h04, 16'h00A0, 4'd3},
    '{5'h08, 16'h0000, 5'h04, 16'h00A0, 4'd3},
    '{5'h0C, 16'h0F0F, 5'h0C, 16'h0F0F, 4'd4},
    '{5'h10, 16'h0003, 5'h10, 16'h0F0C, 4'd4},
    '{5'h0C, 16'h0000, 5'h0C, 16'h0F0C, 4'd4},
    '{5'h04, 16'hFFFF, 5'h04, 16'h0FFF, 4'd11},
    '{5'h0C, 16'hF000, 5'h0C, 16'h0F0C, 4'd11},
    '{5'h14, 16'hFFFF, 5'h14, 16'h0000, 4'd1},
    '{5'h1C, 16'h1234, 5'h08, 16'h0FFF, 4'd1},
    '{5'h08, 16'hFFFF, 5'h04, 16'h0000, 4'd3},
    '{5'h10, 16'hFFFF, 5'h0C, 16'h0000, 4'd4}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] r);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    r = bus_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] s);
    @(negedge clk);
    src_i = s;
    @(negedge clk);
    src_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    check("R2 irq", {15'b0, irq_o}, 16'h0000);
    rd(A_STAT, v); check("R2 status", v, 16'h0000);
    rd(A_ENS, v);  check("R2 enable", v, 16'h0000);
    rd(A_MKC, v);  check("R2 mask", v, 16'h0000);

    // table walk: R1 R3 R4 R11
    foreach (TBL[i]) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd(TBL[i].ra, v);
      check($sformatf("R%0d table step %0d", TBL[i].rq, i), v, TBL[i].ex);
    end
    rd(5'h18, v); check("R1 unmapped 0x18", v, 16'h0000);
    rd(5'h02, v); check("R1 misaligned", v, 16'h0000);

    // R5 capture only when enabled, latched after input drops
    wr(A_ENS, 16'h0003);
    pulse(12'h005);
    rd(A_STAT, v); check("R5 capture", v, 16'h0001);
    repeat (2) @(negedge clk);
    check("R9 mask clear holds irq low", {15'b0, irq_o}, 16'h0000);

    // R8 one-edge latency
    wr(A_MKS, 16'h0001);
    check("R8 before edge", {15'b0, irq_o}, 16'h0000);
    @(negedge clk);
    check("R8 after edge", {15'b0, irq_o}, 16'h0001);

    // R9 enable clear alone keeps irq
    wr(A_ENC, 16'h0001);
    @(negedge clk);
    check("R9 enable-only clear irq", {15'b0, irq_o}, 16'h0001);
    rd(A_STAT, v); check("R9 pending kept", v, 16'h0001);
    wr(A_MKC, 16'h0001);
    @(negedge clk);
    check("R9 both cleared irq", {15'b0, irq_o}, 16'h0000);
    wr(A_STAT, 16'h0001);
    @(negedge clk); src_i = 12'h001;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R9 silent status", v, 16'h0000);
    check("R9 silent irq", {15'b0, irq_o}, 16'h0000);
    src_i = '0;

    // R6 acknowledge
    wr(A_ENS, 16'h0006);
    pulse(12'h006);
    rd(A_STAT, v); check("R6 pre-ack", v, 16'h0006);
    wr(A_STAT, 16'h0002);
    rd(A_STAT, v); check("R6 ack one bit", v, 16'h0004);
    wr(A_STAT, 16'h0000);
    rd(A_STAT, v); check("R6 zero write", v, 16'h0004);

    // R7 capture beats acknowledge
    @(negedge clk); src_i = 12'h004;
    wr(A_STAT, 16'h0004);
    rd(A_STAT, v); check("R7 level reassert", v, 16'h0004);
    src_i = '0;
    wr(A_STAT, 16'h0004);
    rd(A_STAT, v); check("R7 cleared after drop", v, 16'h0000);

    // R10 shutdown sequence
    wr(A_ENS, 16'hFFFF);
    wr(A_MKS, 16'hFFFF);
    @(negedge clk); src_i = 12'hFFF;
    repeat (2) @(negedge clk);
    check("R8 all active irq", {15'b0, irq_o}, 16'h0001);
    wr(A_ENC, 16'hFFFF);
    wr(A_MKC, 16'hFFFF);
    wr(A_STAT, 16'hFFFF);
    rd(A_STAT, v); check("R10 status", v, 16'h0000);
    rd(A_ENS, v);  check("R10 enable", v, 16'h0000);
    rd(A_MKS, v);  check("R10 mask", v, 16'h0000);
    check("R10 irq", {15'b0, irq_o}, 16'h0000);
    src_i = '0;
    rd(A_UN3, v); check("R1 unmapped 0x1C", v, 16'h0000);
    rd(A_UN1, v); check("R1 unmapped 0x14", v, 16'h0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule